// File: doc/BRIEF.md
# Switchable Program Bank Translator

This block turns a 16-bit processor address into a physical offset for program storage or for a small work memory. Addresses in the upper 32 KB window (0x8000 to 0xFFFF) are steered to a linear program-ROM offset. That offset is built from a 5-bit bank register and a 2-bit layout mode. Addresses in the 8 KB window at 0x6000 to 0x7FFF are steered to a work-RAM offset. That window serves both reads and writes.

The layout mode sets how the bank register is read. Two modes switch a whole 32 KB span at once, and the register's lowest bit has no effect in them. One mode keeps the lowest bank fixed under the lower 16 KB half and lets the register pick the bank under the upper half. The last mode does the opposite: the register picks the bank under the lower half, and the highest bank stays fixed under the upper half.

The ROM size is a parameter, given as a power-of-two count of 16 KB banks. Any bank number beyond the ROM wraps around by masking. The block is purely combinational, so a surrounding memory controller can use its outputs in the same cycle as the address.

Top module: `prg_bank_xlat`

## Requirements
- R1: `rom_sel_o` is 1 exactly when `cpu_addr_i[15]` is 1. `ram_sel_o` is 1 exactly when `cpu_addr_i[15:13]` equals 3'b011 (0x6000 to 0x7FFF). The two selects are never 1 together.
- R2: For any address below 0x6000, both selects are 0.
- R3: When `rom_sel_o` is 1, `rom_addr_o[13:0]` equals `cpu_addr_i[13:0]`.
- R4: In modes 0 and 1, the bank field is `{bank_sel_i[4:1], cpu_addr_i[14]}` before reduction. This maps one contiguous 32 KB span, and `bank_sel_i[0]` has no effect.
- R5: In mode 2, addresses 0x8000 to 0xBFFF use bank 0, and addresses 0xC000 to 0xFFFF use `bank_sel_i`.
- R6: In mode 3, addresses 0x8000 to 0xBFFF use `bank_sel_i`, and addresses 0xC000 to 0xFFFF use the last bank, NUM_BANKS-1.
- R7: The bank number is reduced modulo NUM_BANKS, which must be a power of two. `rom_addr_o` is 14+log2(NUM_BANKS) bits wide and equals bank*16384 + offset.
- R8: When `ram_sel_o` is 1, `ram_addr_o` equals the address minus 0x6000, which is `cpu_addr_i[12:0]`.
- R9: `rom_addr_o` is 0 whenever `rom_sel_o` is 0, and `ram_addr_o` is 0 whenever `ram_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr_i | input | 16 | Processor address |
| bank_sel_i | input | 5 | Bank register value |
| bank_mode_i | input | 2 | Layout mode (0..3) |
| rom_addr_o | output | 14+log2(NUM_BANKS) | Linear program-ROM offset |
| ram_addr_o | output | 13 | Work-RAM offset |
| rom_sel_o | output | 1 | Program-ROM window hit |
| ram_sel_o | output | 1 | Work-RAM window hit |

## Verification
The bench builds two copies of the block. The first uses NUM_BANKS=8: register values 8 to 31 then wrap, and the fixed last bank is 7. The second uses NUM_BANKS=2: the 32 KB modes fill the whole ROM and every mode reduces to one bank bit. Both copies receive the same address sweep across every mode and a set of register values that includes odd numbers and values beyond the ROM size. This brings the wrap-around, the ignored low bit and the fixed-bank halves into view at two different address widths.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;
  localparam int unsigned CPU_AW    = 16;
  localparam int unsigned BANK_OFS_W = 14;
  localparam int unsigned RAM_AW    = 13;
  localparam logic [2:0]  RAM_WIN_TAG = 3'b011;

  typedef enum logic [1:0] {
    MODE_SPAN_A    = 2'd0,
    MODE_SPAN_B    = 2'd1,
    MODE_PIN_FIRST = 2'd2,
    MODE_PIN_LAST  = 2'd3
  } bank_mode_e;
endpackage

// File: rtl/prg_window_decode.sv
module prg_window_decode
  import prg_xlat_pkg::*;
(
  input  logic [CPU_AW-1:0] cpu_addr_i,
  output logic              rom_hit_o,
  output logic              ram_hit_o,
  output logic              upper_half_o
);
  always_comb begin
    rom_hit_o    = cpu_addr_i[CPU_AW-1];
    ram_hit_o    = (cpu_addr_i[CPU_AW-1:CPU_AW-3] == RAM_WIN_TAG);
    upper_half_o = cpu_addr_i[BANK_OFS_W];
  end

  always_comb begin
    p_sel_excl_r1: assert (!(rom_hit_o && ram_hit_o))
      else $error("rom and ram window both hit");
    p_low_none_r2: assert ((cpu_addr_i >= 16'h6000) || (!rom_hit_o && !ram_hit_o))
      else $error("select active below 0x6000");
  end
endmodule

// File: rtl/prg_bank_select.sv
module prg_bank_select
  import prg_xlat_pkg::*;
#(
  parameter int unsigned BANK_REG_W = 5
) (
  input  logic [1:0]            bank_mode_i,
  input  logic [BANK_REG_W-1:0] bank_sel_i,
  input  logic                  upper_half_i,
  output logic [BANK_REG_W-1:0] bank_raw_o
);
  bank_mode_e mode;

  always_comb begin
    mode = bank_mode_e'(bank_mode_i);
    unique case (mode)
      MODE_SPAN_A, MODE_SPAN_B: bank_raw_o = {bank_sel_i[BANK_REG_W-1:1], upper_half_i};
      MODE_PIN_FIRST:           bank_raw_o = upper_half_i ? bank_sel_i : '0;
      MODE_PIN_LAST:            bank_raw_o = upper_half_i ? '1 : bank_sel_i;
      default:                  bank_raw_o = '0;
    endcase
  end

  always_comb begin
    p_pin_first_r5: assert (!(mode == MODE_PIN_FIRST && !upper_half_i) || bank_raw_o == '0)
      else $error("fixed-first half not bank 0");
    p_pin_last_r6: assert (!(mode == MODE_PIN_LAST && upper_half_i) || bank_raw_o == '1)
      else $error("fixed-last half not last bank");
    p_span_pair_r4: assert (!(mode == MODE_SPAN_A || mode == MODE_SPAN_B) ||
                            bank_raw_o[BANK_REG_W-1:1] == bank_sel_i[BANK_REG_W-1:1])
      else $error("span mode lost upper bank bits");
  end
endmodule

// File: rtl/prg_bank_mask.sv
module prg_bank_mask #(
  parameter int unsigned BANK_REG_W = 5,
  parameter int unsigned NUM_BANKS  = 8,
  localparam int unsigned IDX_W_RAW = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W     = (IDX_W_RAW == 0) ? 1 : IDX_W_RAW
) (
  input  logic [BANK_REG_W-1:0] bank_raw_i,
  output logic [IDX_W-1:0]      bank_idx_o
);
  if ((NUM_BANKS & (NUM_BANKS - 1)) != 0 || NUM_BANKS == 0) begin : g_bad_count
    $error("NUM_BANKS must be a power of two");
  end
  if (IDX_W_RAW > BANK_REG_W) begin : g_bad_width
    $error("NUM_BANKS exceeds bank register reach");
  end

  // power-of-two count: modulo is a truncation
  if (IDX_W_RAW == 0) begin : g_single
    assign bank_idx_o = '0;
  end else begin : g_multi
    assign bank_idx_o = bank_raw_i[IDX_W-1:0];
  end
endmodule

// File: rtl/prg_bank_xlat.sv
module prg_bank_xlat
  import prg_xlat_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 8,
  parameter int unsigned BANK_REG_W = 5,
  localparam int unsigned IDX_W_RAW = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W     = (IDX_W_RAW == 0) ? 1 : IDX_W_RAW,
  localparam int unsigned ROM_AW    = BANK_OFS_W + IDX_W_RAW
) (
  input  logic [CPU_AW-1:0]     cpu_addr_i,
  input  logic [BANK_REG_W-1:0] bank_sel_i,
  input  logic [1:0]            bank_mode_i,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  rom_sel_o,
  output logic                  ram_sel_o
);
  logic                  rom_hit, ram_hit, upper_half;
  logic [BANK_REG_W-1:0] bank_raw;
  logic [IDX_W-1:0]      bank_idx;
  logic [ROM_AW-1:0]     rom_lin;

  prg_window_decode i_decode (
    .cpu_addr_i   (cpu_addr_i),
    .rom_hit_o    (rom_hit),
    .ram_hit_o    (ram_hit),
    .upper_half_o (upper_half)
  );

  prg_bank_select #(.BANK_REG_W(BANK_REG_W)) i_select (
    .bank_mode_i  (bank_mode_i),
    .bank_sel_i   (bank_sel_i),
    .upper_half_i (upper_half),
    .bank_raw_o   (bank_raw)
  );

  prg_bank_mask #(.BANK_REG_W(BANK_REG_W), .NUM_BANKS(NUM_BANKS)) i_mask (
    .bank_raw_i (bank_raw),
    .bank_idx_o (bank_idx)
  );

  if (IDX_W_RAW == 0) begin : g_one_bank
    assign rom_lin = cpu_addr_i[BANK_OFS_W-1:0];
  end else begin : g_banked
    assign rom_lin = {bank_idx[IDX_W_RAW-1:0], cpu_addr_i[BANK_OFS_W-1:0]};
  end

  always_comb begin
    rom_sel_o  = rom_hit;
    ram_sel_o  = ram_hit;
    rom_addr_o = rom_hit ? rom_lin : '0;
    ram_addr_o = ram_hit ? cpu_addr_i[RAM_AW-1:0] : '0;
  end

  always_comb begin
    p_rom_ofs_r3: assert (!rom_sel_o || rom_addr_o[BANK_OFS_W-1:0] == cpu_addr_i[BANK_OFS_W-1:0])
      else $error("rom offset mismatch");
    p_ram_ofs_r8: assert (!ram_sel_o || {3'b011, ram_addr_o} == cpu_addr_i)
      else $error("ram offset mismatch");
    p_idle_zero_r9: assert ((rom_sel_o || rom_addr_o == '0) && (ram_sel_o || ram_addr_o == '0))
      else $error("unselected address not zero");
  end
endmodule

// File: tb/test_prg_bank_xlat.sv
module test_prg_bank_xlat;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [15:0] addr = '0;
  logic [4:0]  sel  = '0;
  logic [1:0]  mode = '0;

  logic [16:0] rom_a;  logic [12:0] ram_a;  logic rs_a, ws_a;
  logic [14:0] rom_b;  logic [12:0] ram_b;  logic rs_b, ws_b;

  prg_bank_xlat #(.NUM_BANKS(8)) i_prg_bank_xlat (
    .cpu_addr_i(addr), .bank_sel_i(sel), .bank_mode_i(mode),
    .rom_addr_o(rom_a), .ram_addr_o(ram_a), .rom_sel_o(rs_a), .ram_sel_o(ws_a));

  prg_bank_xlat #(.NUM_BANKS(2)) i_prg_bank_xlat_b2 (
    .cpu_addr_i(addr), .bank_sel_i(sel), .bank_mode_i(mode),
    .rom_addr_o(rom_b), .ram_addr_o(ram_b), .rom_sel_o(rs_b), .ram_sel_o(ws_b));

  typedef struct {
    string tag;
    int    rom8, rom2, ram, rsel, wsel;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int model_rom(int a, int s, int m, int nb);
    int ofs = a & 16'h3FFF;
    if (a < 16'h8000) return 0;
    case (m)
      0, 1: return (((s & ~1) % nb) * 16384) + (a - 16'h8000) % (nb * 16384);
      2:    return (a < 16'hC000) ? ofs : ((s % nb) * 16384 + ofs);
      default: return (a < 16'hC000) ? ((s % nb) * 16384 + ofs) : ((nb - 1) * 16384 + ofs);
    endcase
  endfunction

  task automatic drive(input int a, input int s, input int m, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a[15:0]; sel = s[4:0]; mode = m[1:0];
    it.tag  = tag;
    it.rsel = (a >= 16'h8000) ? 1 : 0;
    it.wsel = (a >= 16'h6000 && a < 16'h8000) ? 1 : 0;
    it.ram  = it.wsel ? (a - 16'h6000) : 0;
    it.rom8 = model_rom(a, s, m, 8);
    it.rom2 = model_rom(a, s, m, 2);
    q.push_back(it);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        cmp(it.tag, "rom_sel n8", int'(rs_a), it.rsel);
        cmp(it.tag, "ram_sel n8", int'(ws_a), it.wsel);
        cmp(it.tag, "rom_sel n2", int'(rs_b), it.rsel);
        cmp(it.tag, "ram_sel n2", int'(ws_b), it.wsel);
        cmp(it.tag, "ram_addr n8", int'(ram_a), it.ram);
        cmp(it.tag, "ram_addr n2", int'(ram_b), it.ram);
        cmp(it.tag, "rom_addr n8", int'(rom_a), it.rom8);
        cmp(it.tag, "rom_addr n2", int'(rom_b), it.rom2);
      end
    end
  end

  initial begin : driver
    int sels[6] = '{0, 1, 5, 6, 13, 31};
    int adrs[6] = '{16'h8000, 16'h9ABC, 16'hBFFF, 16'hC000, 16'hE5A5, 16'hFFFF};
    // idle state at address 0
    drive(16'h0000, 0, 0, "R2");
    drive(16'h5FFF, 31, 3, "R2");
    drive(16'h1234, 7, 1, "R9");
    drive(16'h6000, 5, 2, "R8");
    drive(16'h7FFF, 5, 3, "R8");
    drive(16'h6ABC, 0, 0, "R1");
    drive(16'h8000, 0, 0, "R1");
    drive(16'hA5A5, 3, 3, "R3");
    // bit 0 of the register must not move the span
    drive(16'h8123, 4, 0, "R4");
    drive(16'h8123, 5, 0, "R4");
    drive(16'hD123, 5, 1, "R4");
    // register beyond ROM size wraps
    drive(16'h8001, 13, 3, "R7");
    drive(16'hC001, 31, 2, "R7");
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          drive(adrs[j], sels[i], m, (m < 2) ? "R4" : (m == 2) ? "R5" : "R6");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule